// File: doc/BRIEF.md
# TLB Management Register File

This block is the register-level front end that software uses to maintain a small translation lookaside buffer. Each entry of the buffer holds a tag word, a data word and an 8-bit translation ID. Software reaches the entries through six registers on a plain register bus: an index register that picks an entry, a tag port and a data port that read or write the picked entry, a process-ID register, a zone register and a search register.

Tag-port traffic carries the translation ID with it. A tag write stamps the entry with the current process ID, and a tag read loads the process-ID register from the entry. A write to the search register looks up the page number of the written value among the valid entries and leaves the result in the index register: the entry number on a hit, or the old index with its top bit set on a miss. The entry matches when the valid bit is set, the page numbers are equal and the entry's ID is zero or equal to the process ID. No permission or zone evaluation takes part in the match.

Top module: `tlbm_top`

## Requirements
- R1: After reset every register reads zero and every entry is invalid, so a search directly after reset misses and the index register then reads 0x8000_0000.
- R2: A read request places the selected register on `rsp_rdata` at the next clock edge, where it is held until the next read request. The register numbers are 0 data port, 1 tag port, 2 process ID, 3 zone, 4 index, 5 search. Numbers 6 and 7 read zero and writes to them are dropped.
- R3: Tag and data accesses select the entry given by index bits [7:0]. When that value is not below the entry count, writes are dropped, reads return zero and a tag read leaves the process ID unchanged.
- R4: A tag-port write stores the full 32-bit word in the selected entry and copies process-ID bits [7:0] into that entry's translation ID.
- R5: A tag-port read returns the entry's tag word and loads the process-ID register with that entry's translation ID, zero-extended to 32 bits.
- R6: Data-port reads and writes touch only the data word of the selected entry and never change the process ID.
- R7: Writes to the process-ID, zone and index registers store the full 32-bit value, which later reads return unchanged.
- R8: A search write compares bits [31:10] of the written value with tag bits [31:10] of every entry whose tag bit 6 (valid) is set and whose translation ID is zero or equal to process-ID bits [7:0]. On a hit the index register becomes the entry number with all other bits zero, and a read in the following cycle returns it.
- R9: When several entries match a search, the lowest entry number is reported.
- R10: A search miss sets bit 31 of the index register and keeps bits [30:0].
- R11: The search register reads zero, and a search changes no entry and no process ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | A register access is presented this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_reg | input | 3 | Register number |
| req_wdata | input | 32 | Write value |
| rsp_rdata | output | 32 | Registered read result |

## Verification
The bench goes after the ID coupling on the tag port. A design that forgot to stamp the ID on a write, or to reload the process ID on a read, would show the wrong process ID on the next read of register 2. Searches are run against a private entry, against global entries and against an invalid entry with a matching page. These catch a match that ignores the ID or the valid bit, or one that reports the highest duplicate instead of the lowest. Index values at and beyond the entry count, plus a value whose bits above bit 7 are set, show whether out-of-range accesses write or leak data and whether the selection decodes the right bits. A miss issued over a non-zero index shows whether the design clears the low bits instead of only raising bit 31.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
  typedef enum logic [2:0] {
    REG_DATA   = 3'd0,
    REG_TAG    = 3'd1,
    REG_PID    = 3'd2,
    REG_ZONE   = 3'd3,
    REG_INDEX  = 3'd4,
    REG_SEARCH = 3'd5
  } tlbm_reg_e;
endpackage

// File: rtl/tlbm_rst_sync.sv
module tlbm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/tlbm_entry_array.sv
module tlbm_entry_array #(
  parameter int N_ENTRIES = 16,
  parameter int REG_W     = 32,
  parameter int ID_W      = 8,
  parameter int SEL_W     = 8,
  parameter int PAGE_LSB  = 10,
  parameter int VALID_BIT = 6,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int PAGE_W   = REG_W - PAGE_LSB
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [SEL_W-1:0]                  sel,
  input  logic                              tag_we,
  input  logic                              data_we,
  input  logic [REG_W-1:0]                  wdata,
  input  logic [ID_W-1:0]                   wtid,
  output logic                              sel_ok,
  output logic [REG_W-1:0]                  sel_tag,
  output logic [REG_W-1:0]                  sel_data,
  output logic [ID_W-1:0]                   sel_tid,
  output logic [N_ENTRIES-1:0][PAGE_W-1:0]  pages,
  output logic [N_ENTRIES-1:0]              valids,
  output logic [N_ENTRIES-1:0][ID_W-1:0]    tids
);
  logic [IDX_W-1:0] sel_i;
  logic [REG_W-1:0] tag_all  [N_ENTRIES];
  logic [REG_W-1:0] data_all [N_ENTRIES];
  logic [ID_W-1:0]  tid_all  [N_ENTRIES];

  assign sel_ok = (int'(sel) < N_ENTRIES);
  assign sel_i  = sel[IDX_W-1:0];

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
    logic             pick;
    logic             tag_en, data_en;
    logic [REG_W-1:0] tag_q, tag_d, data_q, data_d;
    logic [ID_W-1:0]  tid_q, tid_d;

    always_comb begin
      pick    = sel_ok && (int'(sel_i) == e);
      tag_en  = tag_we && pick;
      data_en = data_we && pick;
      tag_d   = wdata;
      data_d  = wdata;
      tid_d   = wtid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q  <= '0;
        data_q <= '0;
        tid_q  <= '0;
      end else begin
        if (tag_en) begin
          tag_q <= tag_d;
          tid_q <= tid_d;
        end
        if (data_en) data_q <= data_d;
      end
    end

    assign tag_all[e]  = tag_q;
    assign data_all[e] = data_q;
    assign tid_all[e]  = tid_q;
    assign pages[e]    = tag_q[REG_W-1:PAGE_LSB];
    assign valids[e]   = tag_q[VALID_BIT];
    assign tids[e]     = tid_q;
  end

  always_comb begin
    sel_tag  = '0;
    sel_data = '0;
    sel_tid  = '0;
    if (sel_ok) begin
      sel_tag  = tag_all[sel_i];
      sel_data = data_all[sel_i];
      sel_tid  = tid_all[sel_i];
    end
  end
endmodule

// File: rtl/tlbm_search.sv
module tlbm_search #(
  parameter int N_ENTRIES = 16,
  parameter int ID_W      = 8,
  parameter int PAGE_W    = 22,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic [PAGE_W-1:0]                 key_page,
  input  logic [ID_W-1:0]                   pid_id,
  input  logic [N_ENTRIES-1:0][PAGE_W-1:0]  pages,
  input  logic [N_ENTRIES-1:0]              valids,
  input  logic [N_ENTRIES-1:0][ID_W-1:0]    tids,
  output logic                              hit,
  output logic [IDX_W-1:0]                  hit_idx
);
  logic [N_ENTRIES-1:0] match;

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_cmp
    assign match[e] = valids[e] && (pages[e] == key_page) &&
                      ((tids[e] == '0) || (tids[e] == pid_id));
  end

  // Scan from the top so the lowest matching entry is the one left standing.
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlbm_top.sv
module tlbm_top
  import tlbm_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int REG_W     = 32,
  parameter int ID_W      = 8,
  parameter int SEL_W     = 8,
  parameter int PAGE_LSB  = 10,
  parameter int VALID_BIT = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [2:0]  req_reg,
  input  logic [31:0] req_wdata,
  output logic [31:0] rsp_rdata
);
  localparam int IDX_W  = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
  localparam int PAGE_W = REG_W - PAGE_LSB;

  logic rst_s_n;
  logic wr_req, rd_req, tag_we, data_we;

  logic [REG_W-1:0] pid_q, pid_d, zone_q, zone_d, idx_q, idx_d, rdata_q, rdata_d;
  logic             pid_en, zone_en, idx_en, rd_en;

  logic                             sel_ok;
  logic [REG_W-1:0]                 sel_tag, sel_data;
  logic [ID_W-1:0]                  sel_tid;
  logic [N_ENTRIES-1:0][PAGE_W-1:0] pages;
  logic [N_ENTRIES-1:0]             valids;
  logic [N_ENTRIES-1:0][ID_W-1:0]   tids;
  logic                             srch_hit;
  logic [IDX_W-1:0]                 srch_idx;

  tlbm_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_s_n)
  );

  always_comb begin
    wr_req  = req_valid && req_write;
    rd_req  = req_valid && !req_write;
    tag_we  = wr_req && (req_reg == REG_TAG);
    data_we = wr_req && (req_reg == REG_DATA);
  end

  tlbm_entry_array #(
    .N_ENTRIES (N_ENTRIES),
    .REG_W     (REG_W),
    .ID_W      (ID_W),
    .SEL_W     (SEL_W),
    .PAGE_LSB  (PAGE_LSB),
    .VALID_BIT (VALID_BIT)
  ) u_array (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .sel      (idx_q[SEL_W-1:0]),
    .tag_we   (tag_we),
    .data_we  (data_we),
    .wdata    (req_wdata),
    .wtid     (pid_q[ID_W-1:0]),
    .sel_ok   (sel_ok),
    .sel_tag  (sel_tag),
    .sel_data (sel_data),
    .sel_tid  (sel_tid),
    .pages    (pages),
    .valids   (valids),
    .tids     (tids)
  );

  tlbm_search #(
    .N_ENTRIES (N_ENTRIES),
    .ID_W      (ID_W),
    .PAGE_W    (PAGE_W)
  ) u_search (
    .key_page (req_wdata[REG_W-1:PAGE_LSB]),
    .pid_id   (pid_q[ID_W-1:0]),
    .pages    (pages),
    .valids   (valids),
    .tids     (tids),
    .hit      (srch_hit),
    .hit_idx  (srch_idx)
  );

  // Process ID: software write (only when the value changes) or tag-port read.
  always_comb begin
    pid_d  = pid_q;
    pid_en = 1'b0;
    if (wr_req && (req_reg == REG_PID) && (req_wdata != pid_q)) begin
      pid_en = 1'b1;
      pid_d  = req_wdata;
    end else if (rd_req && (req_reg == REG_TAG) && sel_ok) begin
      pid_en = 1'b1;
      pid_d  = {{(REG_W-ID_W){1'b0}}, sel_tid};
    end
  end

  always_comb begin
    zone_d  = req_wdata;
    zone_en = wr_req && (req_reg == REG_ZONE) && (req_wdata != zone_q);
  end

  // Index: direct write, or the outcome of a search.
  always_comb begin
    idx_d  = idx_q;
    idx_en = 1'b0;
    if (wr_req && (req_reg == REG_INDEX)) begin
      idx_en = 1'b1;
      idx_d  = req_wdata;
    end else if (wr_req && (req_reg == REG_SEARCH)) begin
      idx_en = 1'b1;
      if (srch_hit) idx_d = {{(REG_W-IDX_W){1'b0}}, srch_idx};
      else          idx_d = {1'b1, idx_q[REG_W-2:0]};
    end
  end

  always_comb begin
    rd_en = rd_req;
    case (req_reg)
      REG_DATA:  rdata_d = sel_data;
      REG_TAG:   rdata_d = sel_tag;
      REG_PID:   rdata_d = pid_q;
      REG_ZONE:  rdata_d = zone_q;
      REG_INDEX: rdata_d = idx_q;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      pid_q   <= '0;
      zone_q  <= '0;
      idx_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (pid_en)  pid_q   <= pid_d;
      if (zone_en) zone_q  <= zone_d;
      if (idx_en)  idx_q   <= idx_d;
      if (rd_en)   rdata_q <= rdata_d;
    end
  end

  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/tlbm_checker.sv
module tlbm_checker
  import tlbm_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int ID_W  = 8,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic [2:0]       req_reg,
  input logic [REG_W-1:0] pid_q,
  input logic [REG_W-1:0] idx_q,
  input logic [REG_W-1:0] rsp_rdata,
  input logic             srch_hit,
  input logic [IDX_W-1:0] srch_idx,
  input logic             sel_ok,
  input logic [ID_W-1:0]  sel_tid,
  input logic [REG_W-1:0] sel_tag
);
  logic wr_c, rd_c;
  assign wr_c = req_valid && req_write;
  assign rd_c = req_valid && !req_write;

  a_r8_hit_loads_index: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && req_reg == REG_SEARCH && srch_hit) |=>
      idx_q == {{(REG_W-IDX_W){1'b0}}, $past(srch_idx)});

  a_r10_miss_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && req_reg == REG_SEARCH && !srch_hit) |=>
      (idx_q[REG_W-1] && idx_q[REG_W-2:0] == $past(idx_q[REG_W-2:0])));

  a_r4_tag_write_stamps_id: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && req_reg == REG_TAG && sel_ok) |=> sel_tid == $past(pid_q[ID_W-1:0]));

  a_r5_tag_read_loads_pid: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && req_reg == REG_TAG && sel_ok) |=>
      (pid_q == {{(REG_W-ID_W){1'b0}}, $past(sel_tid)} && rsp_rdata == $past(sel_tag)));

  a_r6_data_keeps_pid: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_reg == REG_DATA) |=> $stable(pid_q));

  a_r3_oob_tag_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && req_reg == REG_TAG && !sel_ok) |=> (rsp_rdata == '0 && $stable(pid_q)));

  a_r11_search_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && req_reg == REG_SEARCH) |=> rsp_rdata == '0);
endmodule

bind tlbm_top tlbm_checker #(
  .REG_W (REG_W),
  .ID_W  (ID_W),
  .IDX_W (IDX_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_s_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_reg   (req_reg),
  .pid_q     (pid_q),
  .idx_q     (idx_q),
  .rsp_rdata (rsp_rdata),
  .srch_hit  (srch_hit),
  .srch_idx  (srch_idx),
  .sel_ok    (sel_ok),
  .sel_tid   (sel_tid),
  .sel_tag   (sel_tag)
);

// File: tb/tlbm_top_tb_top.sv
module tlbm_top_tb_top;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [2:0]  req_reg;
  logic [31:0] req_wdata;
  logic [31:0] rsp_rdata;

  always #4 clk = ~clk;

  tlbm_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_reg   (req_reg),
    .req_wdata (req_wdata),
    .rsp_rdata (rsp_rdata)
  );

  // Behavioural reference state
  logic [31:0] m_tag [N];
  logic [31:0] m_data[N];
  logic [7:0]  m_tid [N];
  logic [31:0] m_pid, m_zone, m_idx, m_rd;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 1'b0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model(bit w, int r, logic [31:0] v);
    int s;
    bit ok;
    bit found;
    s  = int'(m_idx[7:0]);
    ok = (s < N);
    if (w) begin
      case (r)
        0: if (ok) m_data[s] = v;
        1: if (ok) begin m_tag[s] = v; m_tid[s] = m_pid[7:0]; end
        2: m_pid  = v;
        3: m_zone = v;
        4: m_idx  = v;
        5: begin
          found = 1'b0;
          for (int i = 0; i < N; i++) begin
            if (!found && m_tag[i][6] && (m_tag[i] >> 10) == (v >> 10) &&
                (m_tid[i] == 8'h00 || m_tid[i] == m_pid[7:0])) begin
              found = 1'b1;
              m_idx = i;
            end
          end
          if (!found) m_idx = m_idx | 32'h8000_0000;
        end
        default: ;
      endcase
    end else begin
      case (r)
        0: m_rd = ok ? m_data[s] : 32'h0;
        1: begin
          m_rd = ok ? m_tag[s] : 32'h0;
          if (ok) m_pid = {24'h0, m_tid[s]};
        end
        2: m_rd = m_pid;
        3: m_rd = m_zone;
        4: m_rd = m_idx;
        default: m_rd = 32'h0;
      endcase
    end
  endtask

  // One bus access: drive at the falling edge, compare the registered
  // read result at the next falling edge.
  task automatic op(bit w, int r, logic [31:0] v, string tag);
    req_valid = 1'b1;
    req_write = w;
    req_reg   = 3'(r);
    req_wdata = v;
    model(w, r, v);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, rsp_rdata, m_rd);
  endtask

  task automatic rd_expect(int r, logic [31:0] exp, string tag);
    op(1'b0, r, 32'h0, tag);
    check(tag, rsp_rdata, exp);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_reg = 3'd0; req_wdata = '0;
    for (int i = 0; i < N; i++) begin m_tag[i] = '0; m_data[i] = '0; m_tid[i] = '0; end
    m_pid = '0; m_zone = '0; m_idx = '0; m_rd = '0;
    repeat (3) @(negedge clk);
    check("R1 rdata in reset", rsp_rdata, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: everything clear, search misses
    for (int r = 0; r < 8; r++) rd_expect(r, 32'h0, "R1 reset read");
    op(1'b1, 5, 32'h0000_0000, "R1 search");
    rd_expect(4, 32'h8000_0000, "R1 miss after reset");

    // R7 register storage
    op(1'b1, 4, 32'h0000_0003, "R7");
    op(1'b1, 2, 32'h0000_0012, "R7");
    op(1'b1, 3, 32'hA5A5_0F0F, "R7");
    rd_expect(2, 32'h0000_0012, "R7 pid");
    rd_expect(3, 32'hA5A5_0F0F, "R7 zone");
    rd_expect(4, 32'h0000_0003, "R7 index");

    // R4 R5 R6 tag/data coupling
    op(1'b1, 1, 32'h0001_0440, "R4 tag write");
    op(1'b1, 0, 32'hDEAD_BEEF, "R6 data write");
    op(1'b1, 2, 32'h0000_0055, "R7");
    rd_expect(0, 32'hDEAD_BEEF, "R6 data read");
    rd_expect(2, 32'h0000_0055, "R6 pid untouched");
    rd_expect(1, 32'h0001_0440, "R5 tag read");
    rd_expect(2, 32'h0000_0012, "R4 R5 pid from entry id");

    // R8 hit with matching private ID
    op(1'b1, 5, 32'h0001_07FF, "R8 search");
    rd_expect(4, 32'h0000_0003, "R8 hit index");
    // R8 ID mismatch -> miss
    op(1'b1, 2, 32'h0000_0055, "R7");
    op(1'b1, 5, 32'h0001_0440, "R8 search");
    rd_expect(4, 32'h8000_0003, "R8 R10 id mismatch miss");

    // R9 two global entries on the same page
    op(1'b1, 2, 32'h0000_0000, "R7");
    op(1'b1, 4, 32'h0000_0005, "R7");
    op(1'b1, 1, 32'h0001_0440, "R4");
    op(1'b1, 4, 32'h0000_0002, "R7");
    op(1'b1, 1, 32'h0001_0440, "R4");
    op(1'b1, 2, 32'h0000_0055, "R7");
    op(1'b1, 5, 32'h0001_0440, "R9 search");
    rd_expect(4, 32'h0000_0002, "R9 lowest match");

    // R8 invalid entry with matching page does not hit
    op(1'b1, 2, 32'h0000_0000, "R7");
    op(1'b1, 4, 32'h0000_0007, "R7");
    op(1'b1, 1, 32'h0002_0000, "R4");
    op(1'b1, 5, 32'h0002_0000, "R8 search");
    rd_expect(4, 32'h8000_0007, "R8 invalid entry ignored");

    // R10 miss keeps low bits, then a hit clears the flag
    op(1'b1, 4, 32'h0000_0123, "R7");
    op(1'b1, 5, 32'h0003_0000, "R10 search");
    rd_expect(4, 32'h8000_0123, "R10 miss keeps bits");
    op(1'b1, 5, 32'h0001_0440, "R8 search");
    rd_expect(4, 32'h0000_0002, "R8 hit clears flag");

    // R3 out-of-range selection and bit decode
    op(1'b1, 4, 32'h0000_0014, "R7");
    op(1'b1, 2, 32'h0000_0077, "R7");
    op(1'b1, 1, 32'h0001_0440, "R3 oob write");
    rd_expect(1, 32'h0000_0000, "R3 oob tag read");
    rd_expect(2, 32'h0000_0077, "R3 pid kept");
    rd_expect(0, 32'h0000_0000, "R3 oob data read");
    op(1'b1, 4, 32'h0000_0010, "R7");
    rd_expect(1, 32'h0000_0000, "R3 boundary index");
    op(1'b1, 4, 32'h0000_0105, "R7");
    rd_expect(1, 32'h0001_0440, "R3 low byte selects");
    rd_expect(2, 32'h0000_0000, "R3 R5 pid from entry");

    // R11 R2
    rd_expect(5, 32'h0000_0000, "R11 search reads zero");
    op(1'b1, 6, 32'hFFFF_FFFF, "R2");
    rd_expect(6, 32'h0000_0000, "R2 unused number");
    rd_expect(7, 32'h0000_0000, "R2 unused number");

    // Mixed traffic against the reference model
    for (int k = 0; k < 600; k++) begin
      int r;
      bit w;
      logic [31:0] v;
      r = $urandom_range(0, 7);
      w = 1'($urandom_range(0, 1));
      case (r)
        1: v = (32'($urandom_range(0, 3)) << 10) | (32'($urandom_range(0, 1)) << 6) |
               32'($urandom_range(0, 63));
        2: v = 32'($urandom_range(0, 3));
        4: v = 32'($urandom_range(0, 18)) |
               (($urandom_range(0, 3) == 0) ? 32'h0000_0100 : 32'h0);
        5: v = (32'($urandom_range(0, 3)) << 10) | 32'($urandom_range(0, 1023));
        default: v = $urandom;
      endcase
      op(w, r, v, "R2 R8 mixed");
    end
    for (int r = 0; r < 6; r++) op(1'b0, r, 32'h0, "R2 final read");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule